// File: doc/BRIEF.md
# User-Level Trap Entry and Return Controller

This block decides, every cycle, whether the pipeline must leave its normal flow for a user-level trap handler or come back from one. Three pipeline stages can raise a synchronous exception in the same cycle: fetch, decode and memory. Each request carries its own cause code and instruction pc, and the memory stage also carries the data address that caused the fault. A timer interrupt line is gated by a global enable bit and a per-source enable bit.

When a trap is taken, the block drives a one-cycle redirect to the handler entry. On the next clock edge it records the trapping pc, the cause and the trap value. It also moves the global enable into a saved previous-enable bit and clears the global enable. The handler entry depends on the two low bits of the vector register. Direct dispatch goes to the base address for every trap. Vectored dispatch sends interrupts to the base plus four times the interrupt code, while exceptions still go to the base. A return request redirects to the saved exception pc and restores the global enable from the previous-enable bit.

Software reaches the vector, exception pc, status and interrupt-enable state through a small write port. Pipeline flushing is left to the surrounding core.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the global enable, previous enable, exception pc, cause and trap value are all zero, and no redirect is driven.
- R2: When several stages request an exception in the same cycle, the memory stage wins over decode and decode wins over fetch. The winner's pc goes to the exception pc register and its 4-bit cause code goes to the cause register, zero extended. The cause codes are: 0 fetch misaligned, 1 fetch access fault, 2 illegal instruction, 4 load misaligned, 5 load fault, 6 store misaligned, 7 store fault, 8 environment call.
- R3: A synchronous exception takes priority over a timer interrupt pending in the same cycle, so cause bit 31 stays 0.
- R4: Trap entry clears the global enable (status bit 0) and copies its old value into the previous-enable bit (status bit 4).
- R5: A trap from the memory stage writes the memory address into the trap value register. Any other trap writes zero there.
- R6: With vector mode 0 (direct), every trap, interrupts included, redirects to the vector base in the same cycle as the request.
- R7: With vector mode 1 (vectored), a timer interrupt redirects to base + 16 (4 × code 4). Exceptions still redirect to the base.
- R8: The vector register's bits [1:0] are the mode and are forced to zero in the base. Modes 2 and 3 act as direct.
- R9: A timer interrupt is taken only when the global enable and the timer enable (interrupt-enable bit 4) are both set. It records cause 0x80000004 and saves the current pc as the exception pc.
- R10: A return request with no trap redirects to the saved exception pc in the same cycle. On the next edge the global enable takes the previous-enable value and the previous-enable bit is set to 1.
- R11: A trap in the same cycle as a return wins. The return is ignored and the redirect goes to the handler.
- R12: The software write port selects with 0 = status (bit 0 global, bit 4 previous), 1 = interrupt enable (bit 4 timer), 2 = vector, 3 = exception pc. A trap or return in the same cycle overrides the software write to the state that trap or return updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchExc | input | 1 | Fetch stage exception request |
| fetchCause | input | 4 | Fetch stage cause code |
| fetchPc | input | 32 | Fetch stage instruction pc |
| decodeExc | input | 1 | Decode stage exception request |
| decodeCause | input | 4 | Decode stage cause code |
| decodePc | input | 32 | Decode stage instruction pc |
| memExc | input | 1 | Memory stage exception request |
| memCause | input | 4 | Memory stage cause code |
| memPc | input | 32 | Memory stage instruction pc |
| memAddr | input | 32 | Faulting data address |
| timerIrq | input | 1 | Timer interrupt request |
| curPc | input | 32 | Pc saved when an interrupt is taken |
| retReq | input | 1 | Return-from-handler request |
| swWe | input | 1 | Software write strobe |
| swSel | input | 2 | Software write target |
| swData | input | 32 | Software write data |
| redirectValid | output | 1 | Pc redirect this cycle |
| redirectPc | output | 32 | Redirect target |
| epcOut | output | 32 | Exception pc register |
| causeOut | output | 32 | Cause register |
| tvalOut | output | 32 | Trap value register |
| intEnOut | output | 1 | Global interrupt enable |
| prevIntEnOut | output | 1 | Saved previous enable |

## Verification
The functions that collide are trap entry and the other sources of state change in the same cycle. The bench raises an exception together with a pending timer interrupt, an exception together with a return request, and an exception together with a software status write. Each collision is driven in a single cycle. It is judged by the redirect target in that cycle and by the cause, the exception pc and the enable bits after the next edge. These values must show the trap winning and the other request leaving no trace.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    SRC_MEM = 2'd0,
    SRC_DEC = 2'd1,
    SRC_FET = 2'd2,
    SRC_IRQ = 2'd3
  } trapSrc_e;

  typedef struct packed {
    logic     trapTake;
    logic     retTake;
    trapSrc_e src;
    logic     swWe;
  } trapStrobe_t;
endpackage

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_pkg::*;
(
  input  logic        fetchExc,
  input  logic        decodeExc,
  input  logic        memExc,
  input  logic        timerIrq,
  input  logic        retReq,
  input  logic        swWe,
  input  logic        ieQ,
  input  logic        timerEnQ,
  output trapStrobe_t strobe
);
  logic irqTaken;

  always_comb begin
    irqTaken        = timerIrq && ieQ && timerEnQ;
    strobe.trapTake = memExc || decodeExc || fetchExc || irqTaken;
    strobe.retTake  = retReq && !strobe.trapTake;
    strobe.swWe     = swWe;
    // oldest stage first, interrupt last
    if (memExc)         strobe.src = SRC_MEM;
    else if (decodeExc) strobe.src = SRC_DEC;
    else if (fetchExc)  strobe.src = SRC_FET;
    else                strobe.src = SRC_IRQ;
  end
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int TIMER_CODE = 4,
  parameter bit VECTOR_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobe_t        strobe,
  input  logic [CAUSE_W-1:0] fetchCause,
  input  logic [XLEN-1:0]    fetchPc,
  input  logic [CAUSE_W-1:0] decodeCause,
  input  logic [XLEN-1:0]    decodePc,
  input  logic [CAUSE_W-1:0] memCause,
  input  logic [XLEN-1:0]    memPc,
  input  logic [XLEN-1:0]    memAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic [1:0]         swSel,
  input  logic [XLEN-1:0]    swData,
  output logic               ieQ,
  output logic               pieQ,
  output logic               timerEnQ,
  output logic [XLEN-1:0]    epcQ,
  output logic [XLEN-1:0]    causeQ,
  output logic [XLEN-1:0]    tvalQ,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);
  localparam int STATUS_PIE_BIT = 4;
  localparam int TIMER_EN_BIT   = TIMER_CODE;
  localparam logic [XLEN-1:0] VEC_OFFSET = XLEN'(TIMER_CODE) << 2;

  logic [XLEN-1:0] tvecQ;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] selPc, selCause, selTval, trapTarget, irqCause;
  logic            vecMode;

  always_comb begin
    irqCause              = '0;
    irqCause[XLEN-1]      = 1'b1;
    irqCause[CAUSE_W-1:0] = CAUSE_W'(TIMER_CODE);
    selTval               = '0;
    unique case (strobe.src)
      SRC_MEM: begin
        selPc    = memPc;
        selCause = XLEN'(memCause);
        selTval  = memAddr;
      end
      SRC_DEC: begin
        selPc    = decodePc;
        selCause = XLEN'(decodeCause);
      end
      SRC_FET: begin
        selPc    = fetchPc;
        selCause = XLEN'(fetchCause);
      end
      default: begin
        selPc    = curPc;
        selCause = irqCause;
      end
    endcase
  end

  generate
    if (VECTOR_EN) begin : g_vec
      assign vecMode = (tvecQ[1:0] == 2'b01);
    end else begin : g_direct
      assign vecMode = 1'b0;
    end
  endgenerate

  always_comb begin
    base       = {tvecQ[XLEN-1:2], 2'b00};
    trapTarget = (vecMode && strobe.src == SRC_IRQ) ? base + VEC_OFFSET : base;
    redirectValid = strobe.trapTake || strobe.retTake;
    redirectPc    = strobe.trapTake ? trapTarget : epcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ      <= 1'b0;
      pieQ     <= 1'b0;
      timerEnQ <= 1'b0;
      epcQ     <= '0;
      causeQ   <= '0;
      tvalQ    <= '0;
      tvecQ    <= '0;
    end else begin
      if (strobe.swWe) begin
        unique case (swSel)
          2'd0: begin
            ieQ  <= swData[0];
            pieQ <= swData[STATUS_PIE_BIT];
          end
          2'd1: timerEnQ <= swData[TIMER_EN_BIT];
          2'd2: tvecQ    <= swData;
          default: epcQ  <= swData;
        endcase
      end
      if (strobe.trapTake) begin
        epcQ   <= selPc;
        causeQ <= selCause;
        tvalQ  <= selTval;
        pieQ   <= ieQ;
        ieQ    <= 1'b0;
      end else if (strobe.retTake) begin
        ieQ  <= pieQ;
        pieQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int TIMER_CODE = 4,
  parameter bit VECTOR_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchExc,
  input  logic [CAUSE_W-1:0] fetchCause,
  input  logic [XLEN-1:0]    fetchPc,
  input  logic               decodeExc,
  input  logic [CAUSE_W-1:0] decodeCause,
  input  logic [XLEN-1:0]    decodePc,
  input  logic               memExc,
  input  logic [CAUSE_W-1:0] memCause,
  input  logic [XLEN-1:0]    memPc,
  input  logic [XLEN-1:0]    memAddr,
  input  logic               timerIrq,
  input  logic [XLEN-1:0]    curPc,
  input  logic               retReq,
  input  logic               swWe,
  input  logic [1:0]         swSel,
  input  logic [XLEN-1:0]    swData,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic               intEnOut,
  output logic               prevIntEnOut
);
  trapStrobe_t strobe;
  logic        timerEnQ;

  trap_ctl u_ctl (
    .fetchExc (fetchExc),
    .decodeExc(decodeExc),
    .memExc   (memExc),
    .timerIrq (timerIrq),
    .retReq   (retReq),
    .swWe     (swWe),
    .ieQ      (intEnOut),
    .timerEnQ (timerEnQ),
    .strobe   (strobe)
  );

  trap_dp #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .TIMER_CODE(TIMER_CODE), .VECTOR_EN(VECTOR_EN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fetchCause   (fetchCause),
    .fetchPc      (fetchPc),
    .decodeCause  (decodeCause),
    .decodePc     (decodePc),
    .memCause     (memCause),
    .memPc        (memPc),
    .memAddr      (memAddr),
    .curPc        (curPc),
    .swSel        (swSel),
    .swData       (swData),
    .ieQ          (intEnOut),
    .pieQ         (prevIntEnOut),
    .timerEnQ     (timerEnQ),
    .epcQ         (epcOut),
    .causeQ       (causeOut),
    .tvalQ        (tvalOut),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc)
  );
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            fetchExc,
  input logic            decodeExc,
  input logic            memExc,
  input logic [XLEN-1:0] memPc,
  input logic [XLEN-1:0] memAddr,
  input logic            timerIrq,
  input logic            retReq,
  input logic            redirectValid,
  input logic [XLEN-1:0] redirectPc,
  input logic [XLEN-1:0] epcOut,
  input logic [XLEN-1:0] causeOut,
  input logic [XLEN-1:0] tvalOut,
  input logic            intEnOut,
  input logic            prevIntEnOut
);
  logic anyExc;
  assign anyExc = fetchExc || decodeExc || memExc;

  AST_TRAP_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    anyExc |=> !intEnOut); // R4
  AST_TRAP_SAVES_IE: assert property (@(posedge clk) disable iff (!rstN)
    anyExc |=> prevIntEnOut == $past(intEnOut)); // R4
  AST_MEM_EPC: assert property (@(posedge clk) disable iff (!rstN)
    memExc |=> epcOut == $past(memPc)); // R2
  AST_MEM_TVAL: assert property (@(posedge clk) disable iff (!rstN)
    memExc |=> tvalOut == $past(memAddr)); // R5
  AST_EXC_OVER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (anyExc && timerIrq) |=> !causeOut[XLEN-1]); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !intEnOut && !anyExc && !retReq) |-> !redirectValid); // R9
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !anyExc && !timerIrq) |-> (redirectValid && redirectPc == epcOut)); // R10
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !anyExc && !timerIrq) |=> (intEnOut == $past(prevIntEnOut) && prevIntEnOut)); // R10
  AST_TRAP_OVER_RET: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && anyExc) |=> !intEnOut); // R11
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchExc, decodeExc, memExc, timerIrq, retReq, swWe;
  logic [3:0]  fetchCause, decodeCause, memCause;
  logic [31:0] fetchPc, decodePc, memPc, memAddr, curPc, swData;
  logic [1:0]  swSel;
  logic        redirectValid, intEnOut, prevIntEnOut;
  logic [31:0] redirectPc, epcOut, causeOut, tvalOut;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  trap_ctrl u_trap_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    fetchExc = 0; decodeExc = 0; memExc = 0; timerIrq = 0; retReq = 0; swWe = 0;
    fetchCause = 0; decodeCause = 0; memCause = 0;
    fetchPc = 0; decodePc = 0; memPc = 0; memAddr = 0; curPc = 0;
    swSel = 0; swData = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic swW(input logic [1:0] sel, input logic [31:0] data);
    swWe = 1; swSel = sel; swData = data;
    tick();
    swWe = 0;
  endtask

  task automatic t_reset();
    chk("R1 ie", {31'd0, intEnOut}, 0);
    chk("R1 pie", {31'd0, prevIntEnOut}, 0);
    chk("R1 epc", epcOut, 0);
    chk("R1 cause", causeOut, 0);
    chk("R1 tval", tvalOut, 0);
    chk("R1 redirect", {31'd0, redirectValid}, 0);
  endtask

  task automatic t_priority();
    swW(2, 32'h1000); swW(0, 32'h1);
    fetchExc = 1; fetchCause = 1; fetchPc = 32'h300;
    decodeExc = 1; decodeCause = 2; decodePc = 32'h200;
    memExc = 1; memCause = 5; memPc = 32'h100; memAddr = 32'h2002;
    #1;
    chk("R6 direct redirect", redirectPc, 32'h1000);
    tick(); clearIn();
    chk("R2 mem epc", epcOut, 32'h100);
    chk("R2 mem cause", causeOut, 5);
    chk("R5 mem tval", tvalOut, 32'h2002);
    chk("R4 ie cleared", {31'd0, intEnOut}, 0);
    chk("R4 pie saved", {31'd0, prevIntEnOut}, 1);
    fetchExc = 1; fetchCause = 1; fetchPc = 32'h300;
    decodeExc = 1; decodeCause = 2; decodePc = 32'h200;
    tick(); clearIn();
    chk("R2 decode epc", epcOut, 32'h200);
    chk("R2 decode cause", causeOut, 2);
    chk("R5 tval zero", tvalOut, 0);
    fetchExc = 1; fetchCause = 0; fetchPc = 32'h302;
    tick(); clearIn();
    chk("R2 fetch epc", epcOut, 32'h302);
    chk("R2 fetch cause", causeOut, 0);
  endtask

  task automatic t_irq();
    swW(2, 32'h1001); swW(1, 32'h10); swW(0, 32'h1);
    timerIrq = 1; curPc = 32'h500;
    #1;
    chk("R7 vectored irq", redirectPc, 32'h1010);
    tick(); clearIn();
    chk("R9 irq cause", causeOut, 32'h80000004);
    chk("R9 irq epc", epcOut, 32'h500);
    decodeExc = 1; decodeCause = 8; decodePc = 32'h600;
    #1;
    chk("R7 vectored exc base", redirectPc, 32'h1000);
    tick(); clearIn();
    chk("R2 ecall cause", causeOut, 8);
    timerIrq = 1; #1;
    chk("R9 gated by status", {31'd0, redirectValid}, 0);
    tick(); clearIn();
    swW(0, 32'h1); swW(1, 32'h0);
    timerIrq = 1; #1;
    chk("R9 gated by timer enable", {31'd0, redirectValid}, 0);
    tick(); clearIn();
    chk("R9 ie kept", {31'd0, intEnOut}, 1);
    swW(1, 32'h10);
    timerIrq = 1; memExc = 1; memCause = 6; memPc = 32'h700; memAddr = 32'h31;
    #1;
    chk("R3 exc target", redirectPc, 32'h1000);
    tick(); clearIn();
    chk("R3 exc cause", causeOut, 6);
    swW(2, 32'h2000); swW(0, 32'h1);
    timerIrq = 1; #1;
    chk("R6 direct irq", redirectPc, 32'h2000);
    tick(); clearIn();
    swW(2, 32'h2003); swW(0, 32'h1);
    timerIrq = 1; #1;
    chk("R8 mode bits masked", redirectPc, 32'h2000);
    tick(); clearIn();
  endtask

  task automatic t_ret();
    swW(3, 32'h444);
    retReq = 1; #1;
    chk("R10 ret valid", {31'd0, redirectValid}, 1);
    chk("R12 R10 ret target", redirectPc, 32'h444);
    tick(); clearIn();
    chk("R10 ie restored", {31'd0, intEnOut}, 1);
    chk("R10 pie set", {31'd0, prevIntEnOut}, 1);
    retReq = 1; memExc = 1; memCause = 7; memPc = 32'h800; memAddr = 32'h900;
    #1;
    chk("R11 trap target", redirectPc, 32'h2000);
    tick(); clearIn();
    chk("R11 ie cleared", {31'd0, intEnOut}, 0);
    chk("R11 epc", epcOut, 32'h800);
    swWe = 1; swSel = 0; swData = 32'h1;
    decodeExc = 1; decodeCause = 2; decodePc = 32'h900;
    tick(); clearIn();
    chk("R12 trap over sw write", {31'd0, intEnOut}, 0);
    chk("R12 epc", epcOut, 32'h900);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1;
    t_priority();
    t_irq();
    t_ret();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule